// File: doc/BRIEF.md
# Multi-rate search and lock controller

This block is the digital control core of a serial reclocker that accepts several line rates. It runs on a reference clock and decides which line rate the recovered clock is running at. An external gate counts recovered-clock edges over a fixed window timed by the reference. At the end of each window it presents that count with a one-cycle strobe. The controller compares each count against integer bounds computed for the rate now under trial.

In automatic mode the controller walks a fixed cyclic list of candidate rates. For each candidate it presents the code on `trial_rate`, which selects the divider ratio. It stays on a candidate for a set number of consecutive failing windows. Lock is declared after two consecutive windows inside a tight window around the nominal count. Lock is held while the count stays inside a looser window. When lock is lost, the search resumes at the same rate. In manual mode the rate comes from an external 3-bit code, and no other rate can lock.

The outputs are the lock flag, an SD/HD indication, and a 3-bit rate code with a drive-enable for a shared bidirectional pin. The enable is high in automatic mode.

Top module: `rate_lock_ctrl`

## Requirements
- R1: A synchronous active-high reset clears `lock_det`, `sd_rate` and `rate_code_out` to 0 and starts the search at code 000. One cycle after reset is released, `trial_rate` reads 000.
- R2: Rate codes are 000=143.2, 001=177.5, 010=270, 011=360, 100=540 and 101=1485 Mb/s. The nominal window count is the rate in tenths of Mb/s times `GATE_SCALE`: 1432, 1775, 2700, 3600, 5400 or 14850 at scale 1. Codes 110 and 111 never lock.
- R3: In automatic mode the candidate order is 000, 001, 010, 011, 100, 101 and then back to 000. The search moves to the next code after `DWELL` consecutive failing strobes on the current code.
- R4: While automatic mode and `asi_mode` are both high, code 001 is skipped (000 goes to 010) and cannot lock.
- R5: `lock_det` rises on the clock edge of the second consecutive strobe whose count lies within nominal ± floor(nominal/100), bounds included.
- R6: While locked, a strobe with a count within nominal ± floor(nominal/50) keeps the lock. A count outside that range clears `lock_det` on that strobe's edge, and the search resumes at the same code.
- R7: `sd_rate` is 1 only while locked at codes 000 to 100. It is 0 while locked at 101 and whenever `lock_det` is 0.
- R8: In manual mode (`auto_sel` low) the rate under trial is `rate_sel_in`, failing strobes do not move it, and only that rate can lock.
- R9: With `HD_EN`=0, code 101 is left out of the search (100 wraps to 000), and a manual code of 101 never locks.
- R10: `rate_code_out` shows the most recently locked code and keeps it after lock is lost. `rate_code_oe` equals `auto_sel` delayed by one cycle.
- R11: While locked, a change of the rate under trial clears `lock_det` on the next clock edge, with no strobe needed. This covers a new manual code.
- R12: A passing strobe during the search restarts the count of consecutive failures, so the search does not advance on failures split by a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| auto_sel | input | 1 | 1 = automatic search, 0 = manual rate |
| asi_mode | input | 1 | Skips code 001 in automatic mode |
| rate_sel_in | input | 3 | Manual rate code |
| meas_valid | input | 1 | One-cycle strobe at the end of a gate window |
| meas_cnt | input | CNT_W | Recovered-clock edge count for that window |
| trial_rate | output | 3 | Code under trial, selects the divider ratio |
| rate_code_out | output | 3 | Most recently locked code |
| rate_code_oe | output | 1 | Drive enable for the rate code pin |
| lock_det | output | 1 | Lock flag |
| sd_rate | output | 1 | 1 when locked at an SD rate |

## Verification
The strobe's own clock edge updates `lock_det`, `sd_rate` and `rate_code_out`. A search step moves the internal candidate on that same edge. `trial_rate` and `rate_code_oe` pass through one more register, so they change one edge later. A lock drop caused by a change of manual code needs no strobe and occurs on the next edge.

Each strobe task drives its inputs on a falling edge and samples the outputs on the following falling edge. Checks of `trial_rate` and `rate_code_oe` wait one further falling edge. No check is taken at an active edge.

// File: rtl/rate_lock_pkg.sv
package rate_lock_pkg;
  typedef logic [2:0] rate_t;

  localparam rate_t RC_143 = 3'd0;
  localparam rate_t RC_177 = 3'd1;
  localparam rate_t RC_540 = 3'd4;
  localparam rate_t RC_HD  = 3'd5;

  // Nominal edges per gate window: rate in 0.1 Mb/s units times scale.
  function automatic int unsigned nom_count(rate_t code, int unsigned scale);
    int unsigned base;
    case (code)
      3'd0:    base = 1432;
      3'd1:    base = 1775;
      3'd2:    base = 2700;
      3'd3:    base = 3600;
      3'd4:    base = 5400;
      3'd5:    base = 14850;
      default: base = 0;
    endcase
    return base * scale;
  endfunction
endpackage

// File: rtl/freq_window.sv
module freq_window
  import rate_lock_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int GATE_SCALE = 1
) (
  input  rate_t            code,
  input  logic [CNT_W-1:0] cnt,
  output logic             in_acq,
  output logic             in_hold
);
  int unsigned nom, tol_acq, tol_hold, c;

  always_comb begin
    nom      = nom_count(code, GATE_SCALE);
    tol_acq  = nom / 100;
    tol_hold = nom / 50;
    c        = 32'(cnt);
    in_acq   = (nom != 0) && (c >= nom - tol_acq)  && (c <= nom + tol_acq);
    in_hold  = (nom != 0) && (c >= nom - tol_hold) && (c <= nom + tol_hold);
  end
endmodule

// File: rtl/rate_stepper.sv
module rate_stepper
  import rate_lock_pkg::*;
#(
  parameter bit HD_EN = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  step_adv,
  input  logic  auto_sel,
  input  logic  asi_mode,
  output rate_t cur_rate
);
  rate_t after_540, nxt;

  generate
    if (HD_EN) begin : g_hd
      assign after_540 = RC_HD;
    end else begin : g_sd_only
      assign after_540 = RC_143;
    end
  endgenerate

  always_comb begin
    case (cur_rate)
      3'd0:    nxt = asi_mode ? 3'd2 : RC_177;
      3'd1:    nxt = 3'd2;
      3'd2:    nxt = 3'd3;
      3'd3:    nxt = RC_540;
      3'd4:    nxt = after_540;
      default: nxt = RC_143;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                       cur_rate <= RC_143;
    else if (auto_sel && step_adv) cur_rate <= nxt;
  end

  a_r8_frozen_in_manual: assert property (@(posedge clk) disable iff (rst)
    !auto_sel |=> $stable(cur_rate));
  a_r4_asi_skips_177: assert property (@(posedge clk) disable iff (rst)
    (auto_sel && asi_mode && step_adv) |=> (cur_rate != RC_177));
  a_r9_no_hd_step: assert property (@(posedge clk) disable iff (rst)
    !HD_EN |-> (cur_rate != RC_HD));
  a_r3_code_range: assert property (@(posedge clk) disable iff (rst)
    cur_rate <= RC_HD);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import rate_lock_pkg::*;
#(
  parameter int DWELL = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  meas_valid,
  input  logic  rate_ok,
  input  logic  in_acq,
  input  logic  in_hold,
  input  rate_t active,
  output logic  step_adv,
  output logic  locked,
  output rate_t lock_rate,
  output logic  sd_flag
);
  localparam int FW = $clog2(DWELL + 1);

  logic          pass_seen;
  logic [FW-1:0] fail_cnt;
  logic          pass_now, drop_now;

  always_comb begin
    pass_now = rate_ok && in_acq;
    step_adv = meas_valid && !locked && !pass_now && (fail_cnt == FW'(DWELL - 1));
    drop_now = locked && ((active != lock_rate) || !rate_ok || (meas_valid && !in_hold));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked    <= 1'b0;
      sd_flag   <= 1'b0;
      lock_rate <= RC_143;
      pass_seen <= 1'b0;
      fail_cnt  <= '0;
    end else if (locked) begin
      if (drop_now) begin
        locked  <= 1'b0;
        sd_flag <= 1'b0;
      end
    end else if (meas_valid) begin
      if (pass_now) begin
        fail_cnt <= '0;
        if (pass_seen) begin
          locked    <= 1'b1;
          lock_rate <= active;
          sd_flag   <= (active != RC_HD);
          pass_seen <= 1'b0;
        end else begin
          pass_seen <= 1'b1;
        end
      end else begin
        pass_seen <= 1'b0;
        fail_cnt  <= step_adv ? '0 : fail_cnt + 1'b1;
      end
    end
  end

  a_r7_sd_needs_lock: assert property (@(posedge clk) disable iff (rst)
    sd_flag |-> locked);
  a_r7_hd_not_sd: assert property (@(posedge clk) disable iff (rst)
    (locked && lock_rate == RC_HD) |-> !sd_flag);
  a_r5_lock_on_pass: assert property (@(posedge clk) disable iff (rst)
    ($rose(locked) && !$past(rst)) |-> $past(meas_valid && rate_ok && in_acq));
  a_r6_drop_has_cause: assert property (@(posedge clk) disable iff (rst)
    ($fell(locked) && !$past(rst)) |->
      $past((meas_valid && !in_hold) || !rate_ok || (active != lock_rate)));
  a_r3_no_step_when_locked: assert property (@(posedge clk) disable iff (rst)
    locked |-> !step_adv);
endmodule

// File: rtl/rate_lock_ctrl.sv
module rate_lock_ctrl
  import rate_lock_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int GATE_SCALE = 1,
  parameter int DWELL      = 4,
  parameter bit HD_EN      = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_sel,
  input  logic             asi_mode,
  input  logic [2:0]       rate_sel_in,
  input  logic             meas_valid,
  input  logic [CNT_W-1:0] meas_cnt,
  output logic [2:0]       trial_rate,
  output logic [2:0]       rate_code_out,
  output logic             rate_code_oe,
  output logic             lock_det,
  output logic             sd_rate
);
  rate_t cur_rate, active, lock_rate;
  logic  rate_ok, in_acq, in_hold, step_adv;

  always_comb begin
    active = auto_sel ? cur_rate : rate_sel_in;
    if (active == RC_HD)                         rate_ok = HD_EN;
    else if (active > RC_HD)                     rate_ok = 1'b0;
    else if (auto_sel && asi_mode && active == RC_177) rate_ok = 1'b0;
    else                                         rate_ok = 1'b1;
  end

  rate_stepper #(.HD_EN(HD_EN)) u_step (
    .clk(clk), .rst(rst), .step_adv(step_adv), .auto_sel(auto_sel),
    .asi_mode(asi_mode), .cur_rate(cur_rate));

  freq_window #(.CNT_W(CNT_W), .GATE_SCALE(GATE_SCALE)) u_win (
    .code(active), .cnt(meas_cnt), .in_acq(in_acq), .in_hold(in_hold));

  lock_fsm #(.DWELL(DWELL)) u_fsm (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .rate_ok(rate_ok),
    .in_acq(in_acq), .in_hold(in_hold), .active(active), .step_adv(step_adv),
    .locked(lock_det), .lock_rate(lock_rate), .sd_flag(sd_rate));

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_rate   <= RC_143;
      rate_code_oe <= 1'b0;
    end else begin
      trial_rate   <= active;
      rate_code_oe <= auto_sel;
    end
  end

  assign rate_code_out = lock_rate;

  a_r8_manual_locks_selected: assert property (@(posedge clk) disable iff (rst)
    ($rose(lock_det) && !auto_sel) |-> (rate_code_out == $past(rate_sel_in)));
  a_r2_no_invalid_lock: assert property (@(posedge clk) disable iff (rst)
    lock_det |-> (rate_code_out <= RC_HD));
endmodule

// File: tb/test_rate_lock_ctrl.sv
module test_rate_lock_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        auto_sel = 1'b1, asi_mode = 1'b0, meas_valid = 1'b0;
  logic [2:0]  rate_sel_in = 3'd0;
  logic [15:0] meas_cnt = '0;
  logic [2:0]  tr, rc, tr2, rc2;
  logic        oe, lk, sd, oe2, lk2, sd2;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_lock_ctrl #(.DWELL(DW), .HD_EN(1'b1)) i_rate_lock_ctrl (
    .clk(clk), .rst(rst), .auto_sel(auto_sel), .asi_mode(asi_mode),
    .rate_sel_in(rate_sel_in), .meas_valid(meas_valid), .meas_cnt(meas_cnt),
    .trial_rate(tr), .rate_code_out(rc), .rate_code_oe(oe),
    .lock_det(lk), .sd_rate(sd));

  rate_lock_ctrl #(.DWELL(DW), .HD_EN(1'b0)) i_rate_lock_ctrl_sd (
    .clk(clk), .rst(rst), .auto_sel(auto_sel), .asi_mode(asi_mode),
    .rate_sel_in(rate_sel_in), .meas_valid(meas_valid), .meas_cnt(meas_cnt),
    .trial_rate(tr2), .rate_code_out(rc2), .rate_code_oe(oe2),
    .lock_det(lk2), .sd_rate(sd2));

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(int c);
    meas_cnt = 16'(c);
    meas_valid = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
  endtask

  task automatic fails(int n);
    for (int i = 0; i < n; i++) strobe(0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic t_reset();
    auto_sel = 1; asi_mode = 0;
    do_reset();
    chk("R1 lock", lk, 0);
    chk("R1 sd", sd, 0);
    chk("R1 code_out", rc, 0);
    chk("R1 trial", tr, 0);
  endtask

  task automatic t_search_order();
    do_reset();
    for (int s = 1; s <= 6; s++) begin
      fails(DW);
      idle(1);
      chk("R3 search order", tr, s % 6);
    end
  endtask

  task automatic t_dwell_restart();
    do_reset();
    fails(2); strobe(1432); fails(2); idle(1);
    chk("R12 pass restarts dwell", tr, 0);
    chk("R12 no lock on single pass", lk, 0);
    fails(1); idle(1);
    chk("R12 advance after dwell", tr, 1);
  endtask

  task automatic t_acquire_hold();
    do_reset();
    fails(2*DW); idle(1);
    chk("R3 at 270", tr, 2);
    strobe(2728);
    chk("R5 above 1pct no lock", lk, 0);
    strobe(2727);
    chk("R5 one pass no lock", lk, 0);
    strobe(2673);
    chk("R5 second pass locks", lk, 1);
    chk("R10 code_out 270", rc, 2);
    chk("R7 sd at 270", sd, 1);
    strobe(2754);
    chk("R6 2pct high holds", lk, 1);
    strobe(2646);
    chk("R6 2pct low holds", lk, 1);
    strobe(2755);
    chk("R6 beyond 2pct drops", lk, 0);
    chk("R7 sd cleared", sd, 0);
    chk("R10 code_out kept", rc, 2);
    idle(1);
    chk("R6 resumes same rate", tr, 2);
    strobe(2700); strobe(2700);
    chk("R6 relock same rate", lk, 1);
  endtask

  task automatic t_hd();
    do_reset();
    fails(5*DW); idle(1);
    chk("R3 at 1485", tr, 5);
    strobe(14850); strobe(14850);
    chk("R2 lock at 1485", lk, 1);
    chk("R7 sd low at HD", sd, 0);
    chk("R2 code_out 101", rc, 5);
  endtask

  task automatic t_asi();
    asi_mode = 1;
    do_reset();
    fails(DW); idle(1);
    chk("R4 skip 177", tr, 2);
    asi_mode = 0;
  endtask

  task automatic t_manual();
    auto_sel = 0; rate_sel_in = 3'd3;
    do_reset();
    idle(1);
    chk("R10 oe low in manual", oe, 0);
    fails(2*DW+1); idle(1);
    chk("R8 trial fixed", tr, 3);
    chk("R8 no lock", lk, 0);
    strobe(3600); strobe(3600);
    chk("R8 manual lock", lk, 1);
    chk("R8 code_out 360", rc, 3);
    rate_sel_in = 3'd4;
    @(negedge clk);
    chk("R11 code change drops lock", lk, 0);
    rate_sel_in = 3'd7;
    strobe(5400); strobe(5400);
    chk("R2 code 111 no lock", lk, 0);
    chk("R10 code_out keeps last", rc, 3);
    auto_sel = 1;
    idle(1);
    chk("R10 oe high in auto", oe, 1);
  endtask

  task automatic t_sd_only();
    auto_sel = 0; rate_sel_in = 3'd5;
    do_reset();
    strobe(14850); strobe(14850);
    chk("R9 manual 101 ignored", lk2, 0);
    auto_sel = 1;
    do_reset();
    fails(4*DW); idle(1);
    chk("R9 at 540", tr2, 4);
    fails(DW); idle(1);
    chk("R9 wrap skips HD", tr2, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_search_order();
    t_dwell_restart();
    t_acquire_hold();
    t_hd();
    t_asi();
    t_manual();
    t_sd_only();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule